// File: doc/BRIEF.md
# Next-PC and Delayed-Branch Fetch Unit

This block holds the program counter of a single-issue, five-stage pipeline that uses four-byte instructions. It drives the fetch address to a single-cycle instruction memory. On each clock edge where it advances, it moves the word being fetched into a decode-stage tag, made of that word's address and a valid bit. Decode reports whether the word it holds is a conditional branch or a jump, along with the target and the branch condition. The block resolves the redirect in that same cycle. By then the word after the branch has already been fetched. The build-time branch policy then decides whether that word is kept or turned into a NOP with its valid bit cleared.

A later stage can raise an exception. It supplies a handler vector, the address of the faulting instruction, a flag saying whether that instruction sits in a branch delay slot, and a cause code. The block steers fetch to the vector. It flushes the word being fetched and records the restart address and the cause. A stall freezes the fetch state unless an exception arrives in the same cycle.

Top module: `npc_fetch_unit`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, the fetch address equals the parameter RESET_VEC and the decode valid bit is 0. On the first edge after release, the decode tag holds RESET_VEC with valid 1.
- R2: In a cycle with no stall, no exception and no redirect, the fetch address advances by 4 and the decode address takes the old fetch address.
- R3: A redirect happens when the decode word is valid and either a jump is signalled or a branch is signalled with its condition true. The next fetch address is then the target input.
- R4: A branch with a false condition does not redirect, and the fetch address advances by 4.
- R5: With POLICY = 0 (delay slot), the word fetched after a valid branch or jump always enters decode with valid 1.
- R6: With POLICY = 1 (squash unless not taken), the word after a valid branch or jump enters decode with valid 1 only when no redirect occurred.
- R7: With POLICY = 2 (likely), the word after a valid branch or jump enters decode with valid 1 only when a redirect occurred.
- R8: During a stall without an exception, the fetch address, the decode address and the decode valid bit all hold, and branch or jump inputs have no effect.
- R9: Branch and jump inputs are ignored while the decode valid bit is 0, and the fetch address advances by 4.
- R10: An exception wins over stall and redirect. The next fetch address is the vector input, and the word being fetched enters decode with valid 0.
- R11: On an exception, the restart output becomes the faulting address, or that address minus 4 when the slot flag is set, and the cause output takes the cause input. Both hold otherwise and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and decode tag |
| dec_br_i | input | 1 | Decode word is a conditional branch |
| dec_jmp_i | input | 1 | Decode word is a jump |
| dec_cond_i | input | 1 | Branch condition outcome |
| dec_target_i | input | PC_W | Branch or jump target |
| exc_i | input | 1 | Exception redirect request |
| exc_vector_i | input | PC_W | Handler address |
| exc_pc_i | input | PC_W | Address of the faulting instruction |
| exc_in_slot_i | input | 1 | Faulting instruction is a delay-slot word |
| exc_cause_i | input | CAUSE_W | Cause code |
| pc_o | output | PC_W | Fetch address to instruction memory |
| dec_pc_o | output | PC_W | Address of the word in decode |
| dec_valid_o | output | 1 | Decode word is to execute (0 = NOP) |
| restart_pc_o | output | PC_W | Recorded restart address |
| cause_o | output | CAUSE_W | Recorded cause code |

## Verification
The bench drives three instances, one per policy, with the same stimulus. It aims at these cases:
- A branch with a true and with a false condition. A unit that confused the policies would keep the slot word when it should squash it, or squash it when it should keep it.
- A branch seen while the decode word is a squashed NOP, or seen during a stall. A unit that did not gate on those would redirect fetch to a stray target.
- An exception arriving together with a stall and a taken branch. A wrong priority would freeze or redirect fetch instead of vectoring.
- A fault in a delay-slot word. A unit that ignored the slot flag would record a restart address 4 bytes too high and skip the branch.

// File: rtl/fetch_pkg.sv
// Shared types for the fetch unit.
// Assumes: the policy encoding is fixed at build time.
package fetch_pkg;
    typedef enum logic [1:0] {
        POL_DELAY     = 2'd0,
        POL_SQUASH_NT = 2'd1,
        POL_LIKELY    = 2'd2
    } br_policy_e;
endpackage

// File: rtl/npc_select.sv
// Next-PC selection: exception over redirect over sequential step.
// Assumes: decode signals describe the word in the decode tag, and that
// word is only honoured when its valid bit is set.
module npc_select #(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic [PC_W-1:0] pc_q,
    input  logic            stall_i,
    input  logic            exc_i,
    input  logic [PC_W-1:0] exc_vector_i,
    input  logic            dec_valid_q,
    input  logic            dec_br_i,
    input  logic            dec_jmp_i,
    input  logic            dec_cond_i,
    input  logic [PC_W-1:0] dec_target_i,
    output logic [PC_W-1:0] npc,
    output logic            advance,
    output logic            take,
    output logic            ctl_seen
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic ctl_live;

    // Qualify decode control with valid bit, stall and exception.
    always_comb begin
        ctl_live = dec_valid_q && !stall_i && !exc_i;
        ctl_seen = ctl_live && (dec_br_i || dec_jmp_i);
        take     = ctl_live && (dec_jmp_i || (dec_br_i && dec_cond_i));
        advance  = exc_i || !stall_i;
    end

    // Priority mux for the next fetch address.
    always_comb begin
        if (exc_i)
            npc = exc_vector_i;
        else if (take)
            npc = dec_target_i;
        else
            npc = pc_q + STEP_V;
    end
endmodule

// File: rtl/slot_keep.sv
// Decides whether the word fetched behind a branch or jump executes.
// Assumes: ctl_seen marks a qualified branch or jump in decode, and take
// marks that it redirects.
module slot_keep #(
    parameter fetch_pkg::br_policy_e POLICY = fetch_pkg::POL_DELAY
) (
    input  logic ctl_seen,
    input  logic take,
    output logic keep
);
    generate
        if (POLICY == fetch_pkg::POL_SQUASH_NT) begin : g_pnt
            // Keep the slot only on fall-through.
            always_comb keep = !ctl_seen || !take;
        end else if (POLICY == fetch_pkg::POL_LIKELY) begin : g_likely
            // Keep the slot only when the redirect happens.
            always_comb keep = !ctl_seen || take;
        end else begin : g_delay
            // The slot always executes.
            always_comb keep = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/exc_capture.sv
// Records the restart address and cause when an exception is raised.
// Assumes: a delay-slot word sits exactly STEP bytes after its branch.
module exc_capture #(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 5,
    parameter int STEP    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_i,
    input  logic [PC_W-1:0]    exc_pc_i,
    input  logic               exc_in_slot_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    output logic [PC_W-1:0]    restart_pc_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic [PC_W-1:0] restart_d;

    // Point back at the branch when the fault is in its slot.
    always_comb restart_d = exc_in_slot_i ? (exc_pc_i - STEP_V) : exc_pc_i;

    // Capture registers, loaded only on an exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_pc_o <= '0;
            cause_o      <= '0;
        end else if (exc_i) begin
            restart_pc_o <= restart_d;
            cause_o      <= exc_cause_i;
        end
    end
endmodule

// File: rtl/npc_fetch_unit.sv
// Fetch unit top: PC register, decode tag register, next-PC selection,
// slot policy and exception capture.
// Assumes: single-cycle instruction memory addressed by pc_o, so the word
// at pc_o enters decode on the next advancing edge.
module npc_fetch_unit #(
    parameter int                    PC_W      = 32,
    parameter int                    CAUSE_W   = 5,
    parameter int                    STEP      = 4,
    parameter logic [PC_W-1:0]       RESET_VEC = 32'h0000_1000,
    parameter fetch_pkg::br_policy_e POLICY    = fetch_pkg::POL_DELAY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic               dec_br_i,
    input  logic               dec_jmp_i,
    input  logic               dec_cond_i,
    input  logic [PC_W-1:0]    dec_target_i,
    input  logic               exc_i,
    input  logic [PC_W-1:0]    exc_vector_i,
    input  logic [PC_W-1:0]    exc_pc_i,
    input  logic               exc_in_slot_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [PC_W-1:0]    dec_pc_o,
    output logic               dec_valid_o,
    output logic [PC_W-1:0]    restart_pc_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] dec_pc_q;
    logic            dec_valid_q;
    logic [PC_W-1:0] npc;
    logic            advance;
    logic            take;
    logic            ctl_seen;
    logic            keep;
    logic            dec_valid_d;

    npc_select #(.PC_W(PC_W), .STEP(STEP)) u_sel (
        .pc_q         (pc_q),
        .stall_i      (stall_i),
        .exc_i        (exc_i),
        .exc_vector_i (exc_vector_i),
        .dec_valid_q  (dec_valid_q),
        .dec_br_i     (dec_br_i),
        .dec_jmp_i    (dec_jmp_i),
        .dec_cond_i   (dec_cond_i),
        .dec_target_i (dec_target_i),
        .npc          (npc),
        .advance      (advance),
        .take         (take),
        .ctl_seen     (ctl_seen)
    );

    slot_keep #(.POLICY(POLICY)) u_keep (
        .ctl_seen (ctl_seen),
        .take     (take),
        .keep     (keep)
    );

    exc_capture #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .STEP(STEP)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_i         (exc_i),
        .exc_pc_i      (exc_pc_i),
        .exc_in_slot_i (exc_in_slot_i),
        .exc_cause_i   (exc_cause_i),
        .restart_pc_o  (restart_pc_o),
        .cause_o       (cause_o)
    );

    // A flushed fetch enters decode as a NOP.
    always_comb dec_valid_d = !exc_i && keep;

    // PC register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_VEC;
        else if (advance)
            pc_q <= npc;
    end

    // Decode tag register: address and valid bit of the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_pc_q    <= RESET_VEC;
            dec_valid_q <= 1'b0;
        end else if (advance) begin
            dec_pc_q    <= pc_q;
            dec_valid_q <= dec_valid_d;
        end
    end

    // Port drive.
    always_comb begin
        pc_o        = pc_q;
        dec_pc_o    = dec_pc_q;
        dec_valid_o = dec_valid_q;
    end
endmodule

// File: rtl/npc_fetch_unit_chk.sv
// Checker for the fetch unit, attached by bind.
// Assumes: it sees only the top-level ports.
module npc_fetch_unit_chk #(
    parameter int                    PC_W      = 32,
    parameter int                    CAUSE_W   = 5,
    parameter int                    STEP      = 4,
    parameter logic [PC_W-1:0]       RESET_VEC = 32'h0000_1000,
    parameter fetch_pkg::br_policy_e POLICY    = fetch_pkg::POL_DELAY
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall_i,
    input logic               dec_br_i,
    input logic               dec_jmp_i,
    input logic               dec_cond_i,
    input logic [PC_W-1:0]    dec_target_i,
    input logic               exc_i,
    input logic [PC_W-1:0]    exc_vector_i,
    input logic [PC_W-1:0]    exc_pc_i,
    input logic               exc_in_slot_i,
    input logic [CAUSE_W-1:0] exc_cause_i,
    input logic [PC_W-1:0]    pc_o,
    input logic [PC_W-1:0]    dec_pc_o,
    input logic               dec_valid_o,
    input logic [PC_W-1:0]    restart_pc_o,
    input logic [CAUSE_W-1:0] cause_o
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic redirect;
    logic quiet;
    always_comb begin
        redirect = dec_valid_o && !stall_i && !exc_i &&
                   (dec_jmp_i || (dec_br_i && dec_cond_i));
        quiet    = !stall_i && !exc_i && !redirect;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == RESET_VEC) && !dec_valid_o);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> (pc_o == $past(pc_o) + STEP_V) && (dec_pc_o == $past(pc_o)));

    p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc_o == $past(dec_target_i));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !exc_i) |=> $stable(pc_o) && $stable(dec_pc_o) && $stable(dec_valid_o));

    p_exc_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (pc_o == $past(exc_vector_i)) && !dec_valid_o);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i && !exc_in_slot_i) |=> restart_pc_o == $past(exc_pc_i));

    p_restart_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i && exc_in_slot_i) |=> restart_pc_o == $past(exc_pc_i) - STEP_V);

    generate
        if (POLICY == fetch_pkg::POL_SQUASH_NT) begin : g_pnt
            p_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
                redirect |=> !dec_valid_o);
        end else if (POLICY == fetch_pkg::POL_LIKELY) begin : g_likely
            p_likely_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_valid_o && dec_br_i && !dec_jmp_i && !dec_cond_i && !stall_i && !exc_i)
                |=> !dec_valid_o);
        end else begin : g_delay
            p_slot_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
                redirect |=> dec_valid_o);
        end
    endgenerate
endmodule

bind npc_fetch_unit npc_fetch_unit_chk #(
    .PC_W(PC_W), .CAUSE_W(CAUSE_W), .STEP(STEP),
    .RESET_VEC(RESET_VEC), .POLICY(POLICY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .dec_br_i(dec_br_i), .dec_jmp_i(dec_jmp_i), .dec_cond_i(dec_cond_i),
    .dec_target_i(dec_target_i), .exc_i(exc_i), .exc_vector_i(exc_vector_i),
    .exc_pc_i(exc_pc_i), .exc_in_slot_i(exc_in_slot_i), .exc_cause_i(exc_cause_i),
    .pc_o(pc_o), .dec_pc_o(dec_pc_o), .dec_valid_o(dec_valid_o),
    .restart_pc_o(restart_pc_o), .cause_o(cause_o)
);

// File: tb/npc_fetch_unit_bench.sv
module npc_fetch_unit_bench;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0, dec_br_i = 1'b0, dec_jmp_i = 1'b0, dec_cond_i = 1'b0;
    logic [31:0] dec_target_i = '0, exc_vector_i = '0, exc_pc_i = '0;
    logic        exc_i = 1'b0, exc_in_slot_i = 1'b0;
    logic [4:0]  exc_cause_i = '0;

    logic [31:0] pc_w [3];
    logic [31:0] dpc_w [3];
    logic        dv_w [3];
    logic [31:0] rs_w [3];
    logic [4:0]  cs_w [3];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    npc_fetch_unit #(.POLICY(fetch_pkg::POL_DELAY)) u_npc_fetch_unit (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .dec_br_i(dec_br_i),
        .dec_jmp_i(dec_jmp_i), .dec_cond_i(dec_cond_i), .dec_target_i(dec_target_i),
        .exc_i(exc_i), .exc_vector_i(exc_vector_i), .exc_pc_i(exc_pc_i),
        .exc_in_slot_i(exc_in_slot_i), .exc_cause_i(exc_cause_i),
        .pc_o(pc_w[0]), .dec_pc_o(dpc_w[0]), .dec_valid_o(dv_w[0]),
        .restart_pc_o(rs_w[0]), .cause_o(cs_w[0]));

    npc_fetch_unit #(.POLICY(fetch_pkg::POL_SQUASH_NT)) u_npc_fetch_unit_pnt (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .dec_br_i(dec_br_i),
        .dec_jmp_i(dec_jmp_i), .dec_cond_i(dec_cond_i), .dec_target_i(dec_target_i),
        .exc_i(exc_i), .exc_vector_i(exc_vector_i), .exc_pc_i(exc_pc_i),
        .exc_in_slot_i(exc_in_slot_i), .exc_cause_i(exc_cause_i),
        .pc_o(pc_w[1]), .dec_pc_o(dpc_w[1]), .dec_valid_o(dv_w[1]),
        .restart_pc_o(rs_w[1]), .cause_o(cs_w[1]));

    npc_fetch_unit #(.POLICY(fetch_pkg::POL_LIKELY)) u_npc_fetch_unit_lk (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .dec_br_i(dec_br_i),
        .dec_jmp_i(dec_jmp_i), .dec_cond_i(dec_cond_i), .dec_target_i(dec_target_i),
        .exc_i(exc_i), .exc_vector_i(exc_vector_i), .exc_pc_i(exc_pc_i),
        .exc_in_slot_i(exc_in_slot_i), .exc_cause_i(exc_cause_i),
        .pc_o(pc_w[2]), .dec_pc_o(dpc_w[2]), .dec_valid_o(dv_w[2]),
        .restart_pc_o(rs_w[2]), .cause_o(cs_w[2]));

    // Reference state per policy.
    logic [31:0] m_pc [3];
    logic [31:0] m_dpc [3];
    logic        m_dv [3];
    logic [31:0] m_rs [3];
    logic [4:0]  m_cs [3];

    task automatic chk(input string tag, input string what, input int mode,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s policy %0d: actual %h expected %h", tag, what, mode, act, exp);
        end
    endtask

    // Expected slot validity from the policy requirements.
    function automatic logic exp_keep(input int mode, input logic seen, input logic taken);
        if (!seen) return 1'b1;
        if (mode == 1) return !taken;
        if (mode == 2) return taken;
        return 1'b1;
    endfunction

    function automatic string keep_tag(input int mode);
        if (mode == 1) return "R6";
        if (mode == 2) return "R7";
        return "R5";
    endfunction

    // Apply one cycle of stimulus, advance the reference, compare at negedge.
    task automatic step(input string tag, input logic st, input logic ex, input logic slot,
                        input logic br, input logic jp, input logic cd,
                        input logic [31:0] tgt, input logic [31:0] vec,
                        input logic [31:0] epc, input logic [4:0] cause);
        logic [31:0] n_pc [3];
        logic [31:0] n_dpc [3];
        logic        n_dv [3];
        logic [31:0] n_rs [3];
        logic [4:0]  n_cs [3];
        string       vtag [3];
        stall_i = st; exc_i = ex; exc_in_slot_i = slot; dec_br_i = br; dec_jmp_i = jp;
        dec_cond_i = cd; dec_target_i = tgt; exc_vector_i = vec; exc_pc_i = epc;
        exc_cause_i = cause;
        for (int m = 0; m < 3; m++) begin
            logic seen, taken;
            n_pc[m] = m_pc[m]; n_dpc[m] = m_dpc[m]; n_dv[m] = m_dv[m];
            n_rs[m] = m_rs[m]; n_cs[m] = m_cs[m]; vtag[m] = tag;
            seen  = m_dv[m] && (br || jp);
            taken = m_dv[m] && (jp || (br && cd));
            if (ex) begin
                n_pc[m] = vec; n_dpc[m] = m_pc[m]; n_dv[m] = 1'b0;
                n_rs[m] = slot ? epc - 32'd4 : epc; n_cs[m] = cause;
            end else if (!st) begin
                n_pc[m]  = taken ? tgt : m_pc[m] + 32'd4;
                n_dpc[m] = m_pc[m];
                n_dv[m]  = exp_keep(m, seen, taken);
                if (seen) vtag[m] = keep_tag(m);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            m_pc[m] = n_pc[m]; m_dpc[m] = n_dpc[m]; m_dv[m] = n_dv[m];
            m_rs[m] = n_rs[m]; m_cs[m] = n_cs[m];
            chk(tag, "pc", m, pc_w[m], m_pc[m]);
            chk(tag, "dec_pc", m, dpc_w[m], m_dpc[m]);
            chk(vtag[m], "dec_valid", m, {31'd0, dv_w[m]}, {31'd0, m_dv[m]});
            chk("R11", "restart", m, rs_w[m], m_rs[m]);
            chk("R11", "cause", m, {27'd0, cs_w[m]}, {27'd0, m_cs[m]});
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4217);
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            chk("R1", "reset pc", m, pc_w[m], RV);
            chk("R1", "reset valid", m, {31'd0, dv_w[m]}, 32'd0);
            m_pc[m] = RV; m_dpc[m] = RV; m_dv[m] = 1'b0; m_rs[m] = '0; m_cs[m] = '0;
        end
        rst_n = 1'b1;
        // R9: branch while decode word invalid right after reset; R1 first word valid.
        step("R9", 0, 0, 0, 1, 0, 1, 32'h0000_8000, '0, '0, '0);
        // R2 plain sequential steps.
        step("R2", 0, 0, 0, 0, 0, 0, '0, '0, '0, '0);
        // R3 taken branch, then R4 not-taken branch.
        step("R3", 0, 0, 0, 1, 0, 1, 32'h0000_2000, '0, '0, '0);
        step("R2", 0, 0, 0, 0, 0, 0, '0, '0, '0, '0);
        step("R4", 0, 0, 0, 1, 0, 0, 32'h0000_3000, '0, '0, '0);
        step("R3", 0, 0, 0, 0, 1, 0, 32'h0000_4000, '0, '0, '0);
        // R8 stall with branch asserted.
        step("R8", 1, 0, 0, 1, 0, 1, 32'h0000_5000, '0, '0, '0);
        step("R8", 1, 0, 0, 0, 1, 0, 32'h0000_5100, '0, '0, '0);
        // R10 exception with stall and taken branch; R11 slot fault.
        step("R10", 1, 1, 1, 1, 0, 1, 32'h0000_6000, 32'h0000_0080, 32'h0000_2004, 5'd9);
        step("R9", 0, 0, 0, 0, 1, 0, 32'h0000_7000, '0, '0, '0);
        step("R10", 0, 1, 0, 0, 0, 0, '0, 32'h0000_0100, 32'h0000_3008, 5'd3);
        for (int i = 0; i < 3000; i++) begin
            logic st, ex, br, jp;
            string tg;
            st = ($urandom % 5) == 0;
            ex = ($urandom % 20) == 0;
            br = ($urandom % 4) == 0;
            jp = !br && (($urandom % 10) == 0);
            tg = ex ? "R10" : st ? "R8" : (br || jp) ? "R3" : "R2";
            step(tg, st, ex, 1'($urandom), br, jp, 1'($urandom),
                 {$urandom, 2'b00} & 32'h000F_FFFC, {$urandom, 2'b00} & 32'h0000_0FFC,
                 {$urandom, 2'b00} & 32'h000F_FFFC, 5'($urandom));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule